// File: doc/BRIEF.md
# Byte-Count Command Splitter

This block turns one transfer request, given as a byte count of up to 24 bits, a direction and a six-bit bus/chip-select template, into the sequence of data command entries that a command-queue SPI master consumes. A request is taken only while the splitter is idle. Each entry goes out on a valid/ready port. Beside each entry the block gives the number of bytes that entry moves, so a transmit feeder or receive collector can track its progress. A one-cycle done pulse follows the last entry.

Counts of 256 or more are broken into power-of-two chunks. Each chunk is one set bit of the count at position 8 or above, and chunks go out from the lowest bit to the highest. One final immediate chunk carries the part below 256. The generator tests one candidate bit per clock. In receive mode the immediate chunk is padded up to a multiple of four bytes. The SPI transfer itself and the data movement happen elsewhere.

Top module: `splt_byte_cmd_splitter`

## Requirements
- R1: `req_ready` is high only while idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While busy, `req_valid` and the request fields have no effect on the entries being issued.
- R2: While the unissued count has any bit at position 8 or above set, the next entry is a chunk entry for the lowest such bit. Its bit 9 is set and its bits 7:0 hold the bit position. The reported byte count is 2 to the power of that position. That bit is then removed from the count.
- R3: When the unissued count is between 1 and 255, one final entry goes out. Its bit 9 is clear and its bits 7:0 hold the count. When it is zero after the chunks, no final entry goes out.
- R4: Every entry has bit 8 set. Bit 16 is set for transmit and bit 17 for receive, never both. Bits 15:10 are the request template. Bits 7:0 follow R2 or R3 and bits 9:8 are as stated.
- R5: In receive mode (`req_rx`=1), the final count is rounded up to the next multiple of 4. Bits 7:0 take the low 8 bits of the rounded value, so a result of 256 shows as 0. The reported byte count is the full rounded value.
- R6: A request for zero bytes issues no entry. `done` is high in the cycle right after the request is taken.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_entry` and `cmd_bytes` hold steady.
- R8: `done` is high for exactly one cycle, the cycle right after the last entry's handshake. `req_ready` is high again in the cycle after that.
- R9: Synchronous active-low reset. While reset is held, `cmd_valid` and `done` are low and `req_ready` is high, even if it is applied in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle, request can be taken |
| req_count | input | 24 | Requested byte count |
| req_rx | input | 1 | 1 = receive, 0 = transmit |
| req_tmpl | input | 6 | Lane mode / bus / chip-select bits for entry bits 15:10 |
| cmd_valid | output | 1 | Entry offered |
| cmd_ready | input | 1 | Entry accepted by the command queue |
| cmd_entry | output | 18 | Command entry |
| cmd_bytes | output | 24 | Bytes moved by the offered entry |
| done | output | 1 | One-cycle pulse after the last entry |

## Verification
The splitting is tried with a range of counts:
- a small transmit count and a lone power of two, which separate the final-entry path from the chunk path;
- counts mixing chunks and a remainder, such as 769 and 0x012345;
- the all-ones count, the longest sequence;
- the top bit alone.

Receive counts of 253, 4 and 1 show whether padding applies only to the final entry and how padding that reaches 256 is encoded. Some runs stall `cmd_ready` to show entries are held and none is lost or repeated. Directed cases cover:
- a zero count;
- a request held high while busy;
- a reset in the middle of a sequence.

// File: rtl/splt_pkg.sv
// Package: shared constants and types for the byte-count command splitter.
// Assumes an 18-bit command entry whose field positions are fixed by the
// downstream command queue that decodes them.
package splt_pkg;
    localparam int CMD_W      = 18;  // entry width
    localparam int IMM_W      = 8;   // immediate / exponent field width
    localparam int DATA_BIT   = 8;   // entry carries data
    localparam int EXP_BIT    = 9;   // field is an exponent
    localparam int TMPL_LSB   = 10;  // template field low bit
    localparam int TMPL_W     = 6;   // template field width
    localparam int TX_BIT     = 16;  // transmit direction
    localparam int RX_BIT     = 17;  // receive direction
    localparam int RX_ALIGN   = 4;   // receive immediate rounding granule

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_EMIT = 2'd2,
        ST_DONE = 2'd3
    } splt_state_e;
endpackage

// File: rtl/splt_bit_scan.sv
// Module: evaluates one candidate bit of the remaining count per call.
// Reports whether any bit at or above the immediate range is still set,
// whether the candidate bit is set, and the count with that bit removed.
// Assumes ptr never points above COUNT_W-1 while above_imm is high.
module splt_bit_scan
    import splt_pkg::*;
#(
    parameter int COUNT_W = 24,
    parameter int PTR_W   = $clog2(COUNT_W)
) (
    input  logic [COUNT_W-1:0] rem,
    input  logic [PTR_W-1:0]   ptr,
    output logic               above_imm,
    output logic               hit,
    output logic [COUNT_W-1:0] rem_next
);
    // Purpose: classify the remaining count and clear the candidate bit.
    always_comb begin
        above_imm = |rem[COUNT_W-1:IMM_W];
        hit       = rem[ptr];
        rem_next  = rem & ~(COUNT_W'(1) << ptr);
    end
endmodule

// File: rtl/splt_entry_fmt.sv
// Module: builds one command entry and its byte count from the chosen
// chunk kind. Chunk entries carry the bit position; the final entry carries
// the immediate count, padded to RX_ALIGN bytes in receive mode.
// Assumes exp_pos < COUNT_W whenever is_exp is high.
module splt_entry_fmt
    import splt_pkg::*;
#(
    parameter int COUNT_W = 24,
    parameter int PTR_W   = $clog2(COUNT_W)
) (
    input  logic               is_exp,
    input  logic [PTR_W-1:0]   exp_pos,
    input  logic [IMM_W-1:0]   imm_cnt,
    input  logic               dir_rx,
    input  logic [TMPL_W-1:0]  tmpl,
    output logic [CMD_W-1:0]   entry,
    output logic [COUNT_W-1:0] bytes
);
    localparam logic [IMM_W:0] ALIGN_M1 = (IMM_W+1)'(RX_ALIGN - 1);

    logic [IMM_W:0] imm_adj;

    // Purpose: pad the immediate count in receive mode.
    always_comb begin
        imm_adj = {1'b0, imm_cnt};
        if (dir_rx) begin
            imm_adj = ({1'b0, imm_cnt} + ALIGN_M1) & ~ALIGN_M1;
        end
    end

    // Purpose: assemble the entry fields and the byte count.
    always_comb begin
        entry                         = '0;
        entry[DATA_BIT]               = 1'b1;
        entry[TX_BIT]                 = ~dir_rx;
        entry[RX_BIT]                 = dir_rx;
        entry[TMPL_LSB +: TMPL_W]     = tmpl;
        if (is_exp) begin
            entry[EXP_BIT]            = 1'b1;
            entry[IMM_W-1:0]          = IMM_W'(exp_pos);
            bytes                     = COUNT_W'(1) << exp_pos;
        end else begin
            entry[IMM_W-1:0]          = imm_adj[IMM_W-1:0];
            bytes                     = COUNT_W'(imm_adj);
        end
    end
endmodule

// File: rtl/splt_ctrl.sv
// Module: sequencer for the splitter. Takes a request while idle, walks the
// candidate bit pointer one step per clock, registers each entry and holds
// it until the handshake, then pulses done for one cycle.
// Assumes the scan and formatter outputs are combinational from its state.
module splt_ctrl
    import splt_pkg::*;
#(
    parameter int COUNT_W = 24,
    parameter int PTR_W   = $clog2(COUNT_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [COUNT_W-1:0] req_count,
    input  logic               req_rx,
    input  logic [TMPL_W-1:0]  req_tmpl,
    input  logic               cmd_ready,
    input  logic               above_imm,
    input  logic               hit,
    input  logic [COUNT_W-1:0] rem_next,
    input  logic [CMD_W-1:0]   fmt_entry,
    input  logic [COUNT_W-1:0] fmt_bytes,
    output logic [COUNT_W-1:0] rem_q,
    output logic [PTR_W-1:0]   ptr_q,
    output logic               dir_q,
    output logic [TMPL_W-1:0]  tmpl_q,
    output logic               req_ready,
    output logic               cmd_valid,
    output logic [CMD_W-1:0]   cmd_entry,
    output logic [COUNT_W-1:0] cmd_bytes,
    output logic               done
);
    localparam logic [PTR_W-1:0] PTR_START = PTR_W'(IMM_W);

    splt_state_e state_q;
    logic        last_q;

    // Purpose: state, remaining count, pointer and entry registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            ptr_q     <= PTR_START;
            dir_q     <= 1'b0;
            tmpl_q    <= '0;
            cmd_entry <= '0;
            cmd_bytes <= '0;
            last_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rem_q   <= req_count;
                        ptr_q   <= PTR_START;
                        dir_q   <= req_rx;
                        tmpl_q  <= req_tmpl;
                        state_q <= (req_count == '0) ? ST_DONE : ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (above_imm) begin
                        if (hit) begin
                            cmd_entry <= fmt_entry;
                            cmd_bytes <= fmt_bytes;
                            rem_q     <= rem_next;
                            last_q    <= (rem_next == '0);
                            state_q   <= ST_EMIT;
                        end else begin
                            ptr_q <= ptr_q + PTR_W'(1);
                        end
                    end else begin
                        cmd_entry <= fmt_entry;
                        cmd_bytes <= fmt_bytes;
                        rem_q     <= '0;
                        last_q    <= 1'b1;
                        state_q   <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (cmd_ready) begin
                        ptr_q   <= ptr_q + PTR_W'(1);
                        state_q <= last_q ? ST_DONE : ST_SCAN;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Purpose: decode the handshake and status outputs from the state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cmd_valid = (state_q == ST_EMIT);
        done      = (state_q == ST_DONE);
    end
endmodule

// File: rtl/splt_byte_cmd_splitter.sv
// Module: top of the byte-count command splitter. Connects the sequencer,
// the bit scanner and the entry formatter.
// Assumes COUNT_W > IMM_W and that the command queue decodes the fixed
// field positions of splt_pkg.
module splt_byte_cmd_splitter
    import splt_pkg::*;
#(
    parameter int COUNT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [COUNT_W-1:0] req_count,
    input  logic               req_rx,
    input  logic [TMPL_W-1:0]  req_tmpl,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [CMD_W-1:0]   cmd_entry,
    output logic [COUNT_W-1:0] cmd_bytes,
    output logic               done
);
    localparam int PTR_W = $clog2(COUNT_W);

    logic [COUNT_W-1:0] rem_q;
    logic [COUNT_W-1:0] rem_next;
    logic [PTR_W-1:0]   ptr_q;
    logic               dir_q;
    logic [TMPL_W-1:0]  tmpl_q;
    logic               above_imm;
    logic               hit;
    logic [CMD_W-1:0]   fmt_entry;
    logic [COUNT_W-1:0] fmt_bytes;

    splt_bit_scan #(.COUNT_W(COUNT_W), .PTR_W(PTR_W)) u_scan (
        .rem       (rem_q),
        .ptr       (ptr_q),
        .above_imm (above_imm),
        .hit       (hit),
        .rem_next  (rem_next)
    );

    splt_entry_fmt #(.COUNT_W(COUNT_W), .PTR_W(PTR_W)) u_fmt (
        .is_exp  (above_imm),
        .exp_pos (ptr_q),
        .imm_cnt (rem_q[IMM_W-1:0]),
        .dir_rx  (dir_q),
        .tmpl    (tmpl_q),
        .entry   (fmt_entry),
        .bytes   (fmt_bytes)
    );

    splt_ctrl #(.COUNT_W(COUNT_W), .PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_count (req_count),
        .req_rx    (req_rx),
        .req_tmpl  (req_tmpl),
        .cmd_ready (cmd_ready),
        .above_imm (above_imm),
        .hit       (hit),
        .rem_next  (rem_next),
        .fmt_entry (fmt_entry),
        .fmt_bytes (fmt_bytes),
        .rem_q     (rem_q),
        .ptr_q     (ptr_q),
        .dir_q     (dir_q),
        .tmpl_q    (tmpl_q),
        .req_ready (req_ready),
        .cmd_valid (cmd_valid),
        .cmd_entry (cmd_entry),
        .cmd_bytes (cmd_bytes),
        .done      (done)
    );
endmodule

// File: rtl/splt_checker.sv
// Module: protocol and field checks on the splitter's ports, bound to the
// top module. Assumes the fixed field positions of splt_pkg.
module splt_checker
    import splt_pkg::*;
#(
    parameter int COUNT_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [CMD_W-1:0]   cmd_entry,
    input logic [COUNT_W-1:0] cmd_bytes,
    input logic               done
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !done));

    assert_exp_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_entry[EXP_BIT]) |->
            (cmd_entry[IMM_W-1:0] >= IMM_W'(IMM_W)) &&
            (cmd_bytes == (COUNT_W'(1) << cmd_entry[IMM_W-1:0])));

    assert_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_entry[DATA_BIT] &&
                       $countones(cmd_entry[RX_BIT:TX_BIT]) == 1));

    assert_rx_round_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_entry[EXP_BIT] && cmd_entry[RX_BIT]) |->
            (cmd_bytes[1:0] == 2'b00));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_entry) && $stable(cmd_bytes)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
endmodule

bind splt_byte_cmd_splitter splt_checker #(.COUNT_W(COUNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_entry (cmd_entry),
    .cmd_bytes (cmd_bytes),
    .done      (done)
);

// File: tb/tb_splt_byte_cmd_splitter.sv
// Bench: walks a vector table of requests, then runs directed reset and
// busy-request cases. Expected entries are derived from the requirements.
module tb_splt_byte_cmd_splitter;
    localparam int CW = 24;
    localparam int NV = 10;
    localparam logic [5:0] T_LO = 6'b010101;
    localparam logic [5:0] T_HI = 6'b101010;

    localparam logic [CW-1:0] V_CNT [NV] = '{24'd5, 24'd256, 24'h000301,
        24'hFFFFFF, 24'd253, 24'd255, 24'h800000, 24'd4, 24'd0, 24'h012345};
    localparam logic V_RX    [NV] = '{0, 0, 1, 0, 1, 0, 1, 1, 0, 1};
    localparam logic V_STALL [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 1};
    localparam logic V_TSEL  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0, 0};
    localparam int   V_N     [NV] = '{1, 1, 3, 17, 1, 1, 1, 1, 0, 5};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [CW-1:0] req_count = '0;
    logic          req_rx = 1'b0;
    logic [5:0]    req_tmpl = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [17:0]   cmd_entry;
    logic [CW-1:0] cmd_bytes;
    logic          done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [17:0]   e_ent [32];
    logic [CW-1:0] e_byt [32];
    int e_n = 0;
    int got_n = 0;
    logic busy_poke = 1'b0;

    splt_byte_cmd_splitter #(.COUNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_count(req_count), .req_rx(req_rx), .req_tmpl(req_tmpl),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_entry(cmd_entry),
        .cmd_bytes(cmd_bytes), .done(done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog R8 actual=%0d cycles expected=<100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected entries per R2..R5: chunks low bit first, then the remainder.
    task automatic build_exp(input logic [CW-1:0] cnt, input logic rx,
                             input logic [5:0] tm);
        int r;
        e_n = 0;
        for (int b = 8; b < CW; b++) begin
            if (cnt[b]) begin
                e_ent[e_n] = {rx, ~rx, tm, 1'b1, 1'b1, 8'(b)};
                e_byt[e_n] = CW'(1) << b;
                e_n++;
            end
        end
        if (cnt[7:0] != 8'd0) begin
            r = int'(cnt[7:0]);
            if (rx) r = ((r + 3) / 4) * 4;
            e_ent[e_n] = {rx, ~rx, tm, 1'b0, 1'b1, 8'(r)};
            e_byt[e_n] = CW'(r);
            e_n++;
        end
    endtask

    task automatic start_req(input logic [CW-1:0] cnt, input logic rx,
                             input logic [5:0] tm);
        @(negedge clk);
        check(req_ready === 1'b1, "R1", "req_ready when idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_count = cnt;
        req_rx    = rx;
        req_tmpl  = tm;
    endtask

    // Collects entries; request is taken at the edge before the first negedge.
    task automatic collect(input logic stall);
        int t = 0;
        int k = 0;
        int last_hs = 0;
        logic hold = 1'b0;
        logic [17:0]   h_ent = '0;
        logic [CW-1:0] h_byt = '0;
        bit fin = 1'b0;
        while (!fin && t < 400) begin
            @(negedge clk);
            t++;
            if (t == 1) begin
                if (busy_poke) req_count = 24'd7;
                else req_valid = 1'b0;
            end
            if (hold) begin
                check(cmd_valid && cmd_entry == h_ent && cmd_bytes == h_byt,
                      "R7", "entry held under stall", 32'(cmd_entry), 32'(h_ent));
                hold = 1'b0;
            end
            if (done) begin
                check(k == e_n, "R3", "entry count at done", k, e_n);
                check(t == last_hs + 1, "R8", "done cycle after last handshake",
                      t, last_hs + 1);
                fin = 1'b1;
            end else if (cmd_valid) begin
                cmd_ready = stall ? ((t % 3) == 0) : 1'b1;
                if (cmd_ready) begin
                    if (k < e_n) begin
                        check(cmd_entry == e_ent[k], "R2", "entry word",
                              32'(cmd_entry), 32'(e_ent[k]));
                        check(cmd_bytes == e_byt[k], "R5", "entry byte count",
                              32'(cmd_bytes), 32'(e_byt[k]));
                    end else begin
                        check(1'b0, "R3", "extra entry", 32'(cmd_entry), 32'd0);
                    end
                    k++;
                    last_hs = t;
                end else begin
                    hold  = 1'b1;
                    h_ent = cmd_entry;
                    h_byt = cmd_bytes;
                end
            end else begin
                cmd_ready = !stall;
            end
        end
        check(fin, "R8", "done seen", 32'(fin), 32'd1);
        got_n = k;
        @(negedge clk);
        check(!done && req_ready, "R8", "done single cycle then idle",
              {30'd0, done, req_ready}, 32'd1);
    endtask

    initial begin
        // Reset state (R9).
        repeat (3) @(negedge clk);
        check(!cmd_valid && !done && req_ready, "R9", "reset outputs",
              {29'd0, cmd_valid, done, req_ready}, 32'd1);
        rst_n = 1'b1;

        // Table walk (R2, R3, R4, R5, R6, R7, R8).
        for (int i = 0; i < NV; i++) begin
            logic [5:0] tm;
            tm = V_TSEL[i] ? T_HI : T_LO;
            build_exp(V_CNT[i], V_RX[i], tm);
            check(e_n == V_N[i], "R2", "table entry count", e_n, V_N[i]);
            start_req(V_CNT[i], V_RX[i], tm);
            collect(V_STALL[i]);
            if (V_CNT[i] == '0)
                check(got_n == 0, "R6", "zero count issues nothing", got_n, 0);
            else
                check(got_n == V_N[i], "R4", "entries issued", got_n, V_N[i]);
        end

        // Request held high while busy is ignored until idle (R1).
        build_exp(24'h000300, 1'b0, T_LO);
        busy_poke = 1'b1;
        start_req(24'h000300, 1'b0, T_LO);
        collect(1'b0);
        check(got_n == 2, "R1", "busy request left sequence intact", got_n, 2);
        busy_poke = 1'b0;
        build_exp(24'd7, 1'b0, T_LO);
        collect(1'b0);
        check(got_n == 1, "R1", "held request taken once idle", got_n, 1);

        // Reset in the middle of a sequence (R9).
        cmd_ready = 1'b0;
        start_req(24'hFFFFFF, 1'b1, T_HI);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        check(cmd_valid === 1'b1, "R9", "entry pending before reset", 32'(cmd_valid), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!cmd_valid && !done && req_ready, "R9", "mid-run reset outputs",
              {29'd0, cmd_valid, done, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_valid && req_ready, "R9", "idle after reset release",
              {30'd0, cmd_valid, req_ready}, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule